// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two byte-sliced ports, A and B. Each slice is an independent channel. A channel either passes the live value of one port to the other, drives a previously captured value, or stops driving both ports. Each bidirectional pin is split into an input vector, an output vector and a per-channel output-enable, so that the pad logic can be placed outside the block.

Every channel holds two capture registers. One samples port A when its capture strobe rises, and the other samples port B when its own strobe rises. Captures happen whatever the enable and direction controls are set to. The strobes are ordinary data inputs. They are sampled on the system clock, and a 0-to-1 change seen between two clock edges triggers a load on the second of those edges.

Top module: `regbus_xcvr`

## Requirements
- R1: After reset, both capture registers of every channel hold zero. This can be seen by replaying stored data with the stored-source selects set to 1.
- R2: With `oe_n[c]`=1, channel c drives neither port: `a_oe[c]`=0, `b_oe[c]`=0, and its slices of `a_out` and `b_out` read zero. Its stored values are kept.
- R3: With `oe_n[c]`=0 and `dir[c]`=0, only port A is driven. `sel_ba[c]`=0 puts the live B slice on `a_out`, and `sel_ba[c]`=1 puts the stored B value there. `b_out` reads zero.
- R4: With `oe_n[c]`=0 and `dir[c]`=1, only port B is driven. `sel_ab[c]`=0 puts the live A slice on `b_out`, and `sel_ab[c]`=1 puts the stored A value there. `a_out` reads zero.
- R5: `a_oe[c]` and `b_oe[c]` are never 1 together.
- R6: When `cap_ab[c]` is 1 at a clock edge after being 0 at the previous edge, the stored A value loads the A slice present at that edge. This happens for any enable and direction setting. Holding the strobe high causes no further loads.
- R7: The same rising-strobe rule applies to `cap_ba[c]` and the B slice.
- R8: Both strobes of a channel may rise on the same edge, and each register then loads its own port.
- R9: The controls, strobes and data of one channel have no effect on the outputs or stored values of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| a_in | input | 16 | Value seen on port A pins, channel c in bits [8c+7:8c] |
| b_in | input | 16 | Value seen on port B pins |
| oe_n | input | 2 | Per-channel output disable, 1 = isolate |
| dir | input | 2 | Per-channel direction, 0 = drive A, 1 = drive B |
| sel_ab | input | 2 | Source for port B: 0 live A, 1 stored A |
| sel_ba | input | 2 | Source for port A: 0 live B, 1 stored B |
| cap_ab | input | 2 | Capture strobe for the A-side register |
| cap_ba | input | 2 | Capture strobe for the B-side register |
| a_out | output | 16 | Value driven onto port A |
| a_oe | output | 2 | Per-channel drive enable for port A |
| b_out | output | 16 | Value driven onto port B |
| b_oe | output | 2 | Per-channel drive enable for port B |

## Verification
The capture assertions assume that a strobe which is low through reset is seen low by the system clock. They also assume that `a_in` and `b_in` are steady at the sampling edge, which is what the synchronous strobe detection needs. The bench holds every strobe at 0 during reset. It changes inputs only on the falling clock edge, so every strobe level and data value is held across a full rising edge. It never treats a strobe held high as a new capture.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
    logic cap_ab;
    logic cap_ba;
  } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel
  import regbus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xcvr_ctl_t    ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic         ld_a;
  logic         ld_b;
  logic [W-1:0] st_a_q, st_a_d;
  logic [W-1:0] st_b_q, st_b_d;

  xcvr_rise_det u_rise_ab (.clk(clk), .rst_n(rst_n), .lvl(ctl.cap_ab), .rise(ld_a));
  xcvr_rise_det u_rise_ba (.clk(clk), .rst_n(rst_n), .lvl(ctl.cap_ba), .rise(ld_b));

  always_comb begin
    st_a_d = st_a_q;
    st_b_d = st_b_q;
    if (ld_a) st_a_d = a_in;
    if (ld_b) st_b_d = b_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_a_q <= '0;
      st_b_q <= '0;
    end else begin
      st_a_q <= st_a_d;
      st_b_q <= st_b_d;
    end
  end

  always_comb begin
    a_oe  = ~ctl.oe_n & ~ctl.dir;
    b_oe  = ~ctl.oe_n &  ctl.dir;
    a_out = '0;
    b_out = '0;
    if (a_oe) a_out = ctl.sel_ba ? st_b_q : b_in;
    if (b_oe) b_out = ctl.sel_ab ? st_a_q : a_in;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 8,
  localparam int BUS_W = NUM_CH * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  a_in,
  input  logic [BUS_W-1:0]  b_in,
  input  logic [NUM_CH-1:0] oe_n,
  input  logic [NUM_CH-1:0] dir,
  input  logic [NUM_CH-1:0] sel_ab,
  input  logic [NUM_CH-1:0] sel_ba,
  input  logic [NUM_CH-1:0] cap_ab,
  input  logic [NUM_CH-1:0] cap_ba,
  output logic [BUS_W-1:0]  a_out,
  output logic [NUM_CH-1:0] a_oe,
  output logic [BUS_W-1:0]  b_out,
  output logic [NUM_CH-1:0] b_oe
);
  logic rst_q_n;

  xcvr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xcvr_ctl_t ctl;
    always_comb begin
      ctl.oe_n   = oe_n[c];
      ctl.dir    = dir[c];
      ctl.sel_ab = sel_ab[c];
      ctl.sel_ba = sel_ba[c];
      ctl.cap_ab = cap_ab[c];
      ctl.cap_ba = cap_ba[c];
    end

    xcvr_channel #(.W(CH_W)) u_ch (
      .clk  (clk),
      .rst_n(rst_q_n),
      .ctl  (ctl),
      .a_in (a_in[c*CH_W +: CH_W]),
      .b_in (b_in[c*CH_W +: CH_W]),
      .a_out(a_out[c*CH_W +: CH_W]),
      .a_oe (a_oe[c]),
      .b_out(b_out[c*CH_W +: CH_W]),
      .b_oe (b_oe[c])
    );
  end
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH*CH_W-1:0] a_in,
  input logic [NUM_CH*CH_W-1:0] b_in,
  input logic [NUM_CH-1:0]      oe_n,
  input logic [NUM_CH-1:0]      dir,
  input logic [NUM_CH-1:0]      sel_ab,
  input logic [NUM_CH-1:0]      sel_ba,
  input logic [NUM_CH-1:0]      cap_ab,
  input logic [NUM_CH-1:0]      cap_ba,
  input logic [NUM_CH*CH_W-1:0] a_out,
  input logic [NUM_CH-1:0]      a_oe,
  input logic [NUM_CH*CH_W-1:0] b_out,
  input logic [NUM_CH-1:0]      b_oe
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_isolate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[c] |-> (!a_oe[c] && !b_oe[c] && a_out[c*CH_W +: CH_W] == '0 && b_out[c*CH_W +: CH_W] == '0));

    assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe[c] && b_oe[c]));

    assert_live_to_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[c] && !dir[c] && !sel_ba[c]) |-> (a_oe[c] && a_out[c*CH_W +: CH_W] == b_in[c*CH_W +: CH_W]));

    assert_live_to_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[c] && dir[c] && !sel_ab[c]) |-> (b_oe[c] && b_out[c*CH_W +: CH_W] == a_in[c*CH_W +: CH_W]));

    assert_capture_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ab[c] && !$past(cap_ab[c])) |=>
        (!(!oe_n[c] && dir[c] && sel_ab[c] && $stable(cap_ab[c])) ||
         b_out[c*CH_W +: CH_W] == $past(a_in[c*CH_W +: CH_W])));

    assert_capture_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ba[c] && !$past(cap_ba[c])) |=>
        (!(!oe_n[c] && !dir[c] && sel_ba[c] && $stable(cap_ba[c])) ||
         a_out[c*CH_W +: CH_W] == $past(b_in[c*CH_W +: CH_W])));
  end
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .a_in(a_in), .b_in(b_in), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;
  localparam int NC = 2;
  localparam int W  = 8;
  localparam int BW = NC * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [NC-1:0] oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0, cap_ab = '0, cap_ba = '0;
  logic [BW-1:0] a_out, b_out;
  logic [NC-1:0] a_oe, b_oe;

  always #2 clk = ~clk;

  regbus_xcvr #(.NUM_CH(NC), .CH_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct {
    logic [BW-1:0] a_out, b_out;
    logic [NC-1:0] a_oe, b_oe, oe_n, dir;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] ref_a [NC];
  logic [W-1:0] ref_b [NC];
  logic [NC-1:0] prev_ab = '0, prev_ba = '0;

  function automatic exp_t predict();
    exp_t e;
    e.a_out = '0; e.b_out = '0; e.a_oe = '0; e.b_oe = '0;
    e.oe_n = oe_n; e.dir = dir;
    for (int c = 0; c < NC; c++) begin
      if (!oe_n[c] && !dir[c]) begin
        e.a_oe[c] = 1'b1;
        e.a_out[c*W +: W] = sel_ba[c] ? ref_b[c] : b_in[c*W +: W];
      end
      if (!oe_n[c] && dir[c]) begin
        e.b_oe[c] = 1'b1;
        e.b_out[c*W +: W] = sel_ab[c] ? ref_a[c] : a_in[c*W +: W];
      end
    end
    return e;
  endfunction

  // Monitor: pop expected items and compare per channel.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        for (int c = 0; c < NC; c++) begin
          string tag;
          tag = e.oe_n[c] ? "R2" : (e.dir[c] ? "R4" : "R3");
          checks++;
          if (a_out[c*W +: W] !== e.a_out[c*W +: W] || b_out[c*W +: W] !== e.b_out[c*W +: W] ||
              a_oe[c] !== e.a_oe[c] || b_oe[c] !== e.b_oe[c]) begin
            errors++;
            $display("FAIL %s/R9 ch%0d: a=%h/%b b=%h/%b expected a=%h/%b b=%h/%b", tag, c,
                     a_out[c*W +: W], a_oe[c], b_out[c*W +: W], b_oe[c],
                     e.a_out[c*W +: W], e.a_oe[c], e.b_out[c*W +: W], e.b_oe[c]);
          end
          checks++;
          if (a_oe[c] && b_oe[c]) begin
            errors++;
            $display("FAIL R5 ch%0d: a_oe=1 b_oe=1 expected at most one", c);
          end
        end
      end
    end
  end

  // Driver: apply stimulus at falling edge, queue expectation, advance model at rising edge.
  task automatic step(input logic [BW-1:0] ai, input logic [BW-1:0] bi,
                      input logic [NC-1:0] on, input logic [NC-1:0] d,
                      input logic [NC-1:0] sab, input logic [NC-1:0] sba,
                      input logic [NC-1:0] cab, input logic [NC-1:0] cba);
    @(negedge clk);
    a_in = ai; b_in = bi; oe_n = on; dir = d; sel_ab = sab; sel_ba = sba;
    cap_ab = cab; cap_ba = cba;
    #1;
    exp_q.push_back(predict());
    -> chk_ev;
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      // R6, R7, R8: load on a rising strobe only.
      if (cap_ab[c] && !prev_ab[c]) ref_a[c] = a_in[c*W +: W];
      if (cap_ba[c] && !prev_ba[c]) ref_b[c] = b_in[c*W +: W];
    end
    prev_ab = cap_ab; prev_ba = cap_ba;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin ref_a[c] = '0; ref_b[c] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: stored values read zero after reset, both directions.
    step(16'hA5A5, 16'h5A5A, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
    step(16'hA5A5, 16'h5A5A, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00);
    checks++;
    if (b_out !== '0) begin
      errors++;
      $display("FAIL R1: b_out=%h expected 0000", b_out);
    end

    // R6 while isolated (R2): capture A, then replay to B.
    step(16'h3C12, 16'h0000, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00);
    step(16'hFFFF, 16'hFFFF, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00); // held high: no reload
    step(16'h0000, 16'h0000, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00);
    // R7 while driving B: capture B, replay to A.
    step(16'h1111, 16'h9E47, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11);
    step(16'h0000, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00);
    // R8: both strobes on one edge, then each side replayed.
    step(16'hC3D2, 16'h6B71, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11);
    step(16'h0000, 16'h0000, 2'b00, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00);
    step(16'h0000, 16'h0000, 2'b00, 2'b10, 2'b11, 2'b11, 2'b00, 2'b00);
    // R9: channel 1 captures while channel 0 replays its own value.
    step(16'h7700, 16'h8800, 2'b00, 2'b01, 2'b01, 2'b00, 2'b10, 2'b10);
    step(16'h0000, 16'h0000, 2'b00, 2'b10, 2'b11, 2'b11, 2'b00, 2'b00);

    // Every control row on both channels, mixed data.
    for (int i = 0; i < 400; i++) begin
      logic [5:0] r0, r1;
      r0 = 6'(i); r1 = 6'($urandom);
      step(16'($urandom), 16'($urandom),
           {r1[0], r0[0]}, {r1[1], r0[1]}, {r1[2], r0[2]}, {r1[3], r0[3]},
           {r1[4], r0[4]}, {r1[5], r0[5]});
    end

    @(negedge clk);
    -> chk_ev;
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule